// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block holds the status code of one message buffer on the transmit side of a CAN controller. The CPU writes a 4-bit code to set up a single send, a send followed by remote-frame answering, or remote-frame answering alone. The protocol engine sends single-cycle strobes when it schedules the buffer, when a frame goes out, when a send fails or arbitration is lost, when a higher-priority buffer displaces this one, and when a filtered remote frame arrives.

The block decodes the current code into three outputs. A transmit request tells the scheduler that the buffer is waiting. A lock flag blocks writes to the buffer contents while the buffer is busy. Three interrupt pulses report completed sends, completed remote answers and remote-triggered scheduling. Bit 0 of the code is the busy bit, and only hardware changes it. After a remote frame has been sent, the buffer changes over to waiting for reception of the answer.

Top module: `can_tx_slot`

## Requirements
- R1: After reset the status is 1000 (idle), the transmit request is low, the lock flag is low and every interrupt pulse is low.
- R2: While not busy, a CPU write stores the written code with bit 0 forced to 0, undefined codes included. The transmit request is high exactly when the status is 1100 (send once) or 1110 (send once then answer remotes).
- R3: The CPU can never set or clear bit 0 (busy). The lock flag equals bit 0 of the status.
- R4: A schedule strobe moves 1100 to 1101 and 1110 to 1111. In any other state it has no effect.
- R5: A success strobe in 1101 moves the status to 1000 when the identifier's remote bit is 0, and to 0010 (receive ready) when that bit is 1. In either case it pulses the send-done interrupt for one cycle.
- R6: A success strobe in 1111 moves the status to 1010 (await remote) and pulses the remote-answer interrupt for one cycle.
- R7: A remote-hit strobe in 1010 moves the status to 1110 and pulses the remote-scheduled interrupt for one cycle.
- R8: Failure and arbitration-lost strobes leave a busy status unchanged.
- R9: While busy, a CPU write whose bits 3:1 are 100 cancels the request and sets the status to 1000. Any other CPU write replaces bits 3:1 and keeps the busy bit set.
- R10: A preempt strobe moves 1101 back to 1100 and 1111 back to 1110.
- R11: When a hardware strobe changes the status in the same cycle as a CPU write, the hardware transition is taken and the CPU write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the status code |
| cpu_code | input | 4 | Code written by the CPU |
| ev_sched | input | 1 | Scheduler selected this buffer |
| ev_ok | input | 1 | Frame sent successfully |
| ev_fail | input | 1 | Send aborted by an error |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_rmt_hit | input | 1 | Filtered remote frame matched this buffer |
| ev_preempt | input | 1 | Displaced by a higher-priority request before frame start |
| id_rtr | input | 1 | Remote bit of the stored identifier |
| status | output | 4 | Current status code |
| tx_req | output | 1 | Transmit request pending |
| locked | output | 1 | Buffer contents blocked to the CPU |
| irq_tx_done | output | 1 | Pulse: send-once frame completed |
| irq_rmt_ans | output | 1 | Pulse: remote answer completed |
| irq_rmt_sched | output | 1 | Pulse: remote frame triggered an answer |

## Verification
The hardest case to reach is a CPU write and a hardware strobe landing in the same cycle. A cancel written during the very cycle of success or scheduling can only be seen from the ports as which transition won. The bench drives both strobes on the same falling edge, once for a schedule and once for a remote hit. It then reads the resulting code, which differs depending on the winner. Rewriting bits 3:1 on a busy buffer is reached by scheduling first and writing afterwards. Success then has to lead to 1010 instead of 1000.

// File: rtl/can_tx_slot.sv
module can_tx_slot #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [CW-1:0] cpu_code,
  input  logic          ev_sched,
  input  logic          ev_ok,
  input  logic          ev_fail,
  input  logic          ev_arb_lost,
  input  logic          ev_rmt_hit,
  input  logic          ev_preempt,
  input  logic          id_rtr,
  output logic [CW-1:0] status,
  output logic          tx_req,
  output logic          locked,
  output logic          irq_tx_done,
  output logic          irq_rmt_ans,
  output logic          irq_rmt_sched
);
  localparam logic [CW-1:0] S_IDLE     = 4'b1000;
  localparam logic [CW-1:0] S_ONCE     = 4'b1100;
  localparam logic [CW-1:0] S_BUSY0    = 4'b1101;
  localparam logic [CW-1:0] S_AWAIT    = 4'b1010;
  localparam logic [CW-1:0] S_ONCE_RTR = 4'b1110;
  localparam logic [CW-1:0] S_BUSY2    = 4'b1111;
  localparam logic [CW-1:0] S_RXRDY    = 4'b0010;

  logic [CW-1:0] st, hw_next, cpu_next;
  logic hw_hit;

  always_comb begin
    hw_hit  = 1'b0;
    hw_next = st;
    case (st)
      S_ONCE:     if (ev_sched) begin hw_hit = 1'b1; hw_next = S_BUSY0; end
      S_ONCE_RTR: if (ev_sched) begin hw_hit = 1'b1; hw_next = S_BUSY2; end
      S_BUSY0: begin
        if (ev_ok)           begin hw_hit = 1'b1; hw_next = id_rtr ? S_RXRDY : S_IDLE; end
        else if (ev_preempt) begin hw_hit = 1'b1; hw_next = S_ONCE; end
      end
      S_BUSY2: begin
        if (ev_ok)           begin hw_hit = 1'b1; hw_next = S_AWAIT; end
        else if (ev_preempt) begin hw_hit = 1'b1; hw_next = S_ONCE_RTR; end
      end
      S_AWAIT:    if (ev_rmt_hit) begin hw_hit = 1'b1; hw_next = S_ONCE_RTR; end
      default: ;
    endcase
  end

  assign cpu_next = !st[0]                       ? {cpu_code[CW-1:1], 1'b0} :
                    (cpu_code[CW-1:1] == 3'b100) ? S_IDLE :
                                                   {cpu_code[CW-1:1], 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      irq_tx_done   <= 1'b0;
      irq_rmt_ans   <= 1'b0;
      irq_rmt_sched <= 1'b0;
    end else begin
      if (hw_hit)      st <= hw_next;
      else if (cpu_wr) st <= cpu_next;
      irq_tx_done   <= (st == S_BUSY0) && ev_ok;
      irq_rmt_ans   <= (st == S_BUSY2) && ev_ok;
      irq_rmt_sched <= (st == S_AWAIT) && ev_rmt_hit;
    end
  end

  assign status = st;
  assign tx_req = (st == S_ONCE) || (st == S_ONCE_RTR);
  assign locked = st[0];

  a_r5_data_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY0 && ev_ok) |=> (irq_tx_done && (status == S_IDLE || status == S_RXRDY)));
  a_r6_answer_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY2 && ev_ok) |=> (irq_rmt_ans && status == S_AWAIT));
  a_r7_remote_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AWAIT && ev_rmt_hit) |=> (irq_rmt_sched && tx_req));
  a_r8_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] && (ev_fail || ev_arb_lost) && !ev_ok && !ev_preempt && !cpu_wr) |=> $stable(status));
  a_r3_cpu_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[0] && cpu_wr && !ev_sched) |=> !locked);
  a_r2_req_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !locked);
  a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_tx_done, irq_rmt_ans, irq_rmt_sched}));
endmodule

// File: tb/sim_can_tx_slot.sv
module sim_can_tx_slot;
  localparam int TCLK = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0, id_rtr = 1'b0;
  logic [3:0] cpu_code = 4'h0;
  logic ev_sched = 0, ev_ok = 0, ev_fail = 0, ev_arb_lost = 0, ev_rmt_hit = 0, ev_preempt = 0;
  logic [3:0] status;
  logic tx_req, locked, irq_tx_done, irq_rmt_ans, irq_rmt_sched;
  int n_run = 0, n_fail = 0;

  localparam logic [5:0] E_SCH = 6'b100000, E_OK = 6'b010000, E_FL = 6'b001000,
                         E_AL = 6'b000100, E_RH = 6'b000010, E_PE = 6'b000001;

  can_tx_slot u0 (.clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_code(cpu_code),
    .ev_sched(ev_sched), .ev_ok(ev_ok), .ev_fail(ev_fail), .ev_arb_lost(ev_arb_lost),
    .ev_rmt_hit(ev_rmt_hit), .ev_preempt(ev_preempt), .id_rtr(id_rtr), .status(status),
    .tx_req(tx_req), .locked(locked), .irq_tx_done(irq_tx_done),
    .irq_rmt_ans(irq_rmt_ans), .irq_rmt_sched(irq_rmt_sched));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] c, input logic [5:0] ev);
    @(negedge clk);
    cpu_wr = w; cpu_code = c;
    {ev_sched, ev_ok, ev_fail, ev_arb_lost, ev_rmt_hit, ev_preempt} = ev;
    @(negedge clk);
    cpu_wr = 0;
    {ev_sched, ev_ok, ev_fail, ev_arb_lost, ev_rmt_hit, ev_preempt} = '0;
  endtask

  task automatic go_idle();
    step(1, 4'b1000, '0);
  endtask

  task automatic t_reset();
    chk("R1 status", {4'h0, status}, 8'h08);
    chk("R1 req/lock", {6'h0, tx_req, locked}, 8'h00);
    chk("R1 irqs", {5'h0, irq_tx_done, irq_rmt_ans, irq_rmt_sched}, 8'h00);
  endtask

  task automatic t_once_data();
    id_rtr = 0;
    step(1, 4'b1100, '0);
    chk("R2 write once", {4'h0, status}, 8'h0C);
    chk("R2 req once", {7'h0, tx_req}, 8'h01);
    step(0, 4'h0, E_SCH);
    chk("R4 sched once", {4'h0, status}, 8'h0D);
    chk("R3 locked busy", {6'h0, tx_req, locked}, 8'h01);
    step(0, 4'h0, E_FL);
    chk("R8 fail holds", {4'h0, status}, 8'h0D);
    step(0, 4'h0, E_AL);
    chk("R8 arb holds", {4'h0, status}, 8'h0D);
    step(0, 4'h0, E_OK);
    chk("R5 data done", {4'h0, status}, 8'h08);
    chk("R5 irq", {5'h0, irq_tx_done, irq_rmt_ans, irq_rmt_sched}, 8'h04);
    @(negedge clk);
    chk("R5 irq one cycle", {7'h0, irq_tx_done}, 8'h00);
  endtask

  task automatic t_once_remote();
    id_rtr = 1;
    step(1, 4'b1100, '0);
    step(0, 4'h0, E_SCH);
    step(0, 4'h0, E_OK);
    chk("R5 remote sent", {4'h0, status}, 8'h02);
    chk("R5 remote irq", {7'h0, irq_tx_done}, 8'h01);
    id_rtr = 0;
    go_idle();
  endtask

  task automatic t_rtr_answer();
    step(1, 4'b1010, '0);
    chk("R2 await no req", {3'h0, status, tx_req}, 8'h14);
    step(0, 4'h0, E_SCH);
    chk("R4 sched ignored", {4'h0, status}, 8'h0A);
    step(0, 4'h0, E_RH);
    chk("R7 remote hit", {4'h0, status}, 8'h0E);
    chk("R7 irq", {5'h0, irq_tx_done, irq_rmt_ans, irq_rmt_sched, tx_req}, 8'h03);
    step(0, 4'h0, E_SCH);
    chk("R4 sched once_rtr", {4'h0, status}, 8'h0F);
    step(0, 4'h0, E_OK);
    chk("R6 answer done", {4'h0, status}, 8'h0A);
    chk("R6 irq", {5'h0, irq_tx_done, irq_rmt_ans, irq_rmt_sched}, 8'h02);
    go_idle();
    chk("R2 back idle", {4'h0, status}, 8'h08);
  endtask

  task automatic t_busy_write();
    step(1, 4'b1101, '0);
    chk("R3 busy bit ignored", {3'h0, status, locked}, 8'h18);
    step(0, 4'h0, E_SCH);
    step(1, 4'b1110, '0);
    chk("R9 rewrite bits", {4'h0, status}, 8'h0F);
    step(1, 4'b1100, '0);
    chk("R3 busy kept", {3'h0, status, locked}, 8'h1B);
    step(1, 4'b1001, '0);
    chk("R9 cancel", {3'h0, status, locked}, 8'h10);
    step(1, 4'b1110, '0);
    step(0, 4'h0, E_SCH);
    step(1, 4'b1110, '0);
    step(0, 4'h0, E_OK);
    chk("R9 rewritten sends answer", {4'h0, status}, 8'h0A);
    go_idle();
  endtask

  task automatic t_preempt();
    step(1, 4'b1100, '0);
    step(0, 4'h0, E_SCH);
    step(0, 4'h0, E_PE);
    chk("R10 preempt once", {3'h0, status, tx_req}, 8'h19);
    step(1, 4'b1110, '0);
    step(0, 4'h0, E_SCH);
    step(0, 4'h0, E_PE);
    chk("R10 preempt once_rtr", {3'h0, status, tx_req}, 8'h1D);
    go_idle();
  endtask

  task automatic t_priority();
    step(1, 4'b1100, '0);
    step(1, 4'b1000, E_SCH);
    chk("R11 sched beats cancel", {4'h0, status}, 8'h0D);
    go_idle();
    step(1, 4'b1010, '0);
    step(1, 4'b1000, E_RH);
    chk("R11 remote beats write", {4'h0, status}, 8'h0E);
    go_idle();
  endtask

  task automatic t_undef();
    step(1, 4'b0110, '0);
    chk("R2 undefined stored", {3'h0, status, tx_req}, 8'h0C);
    step(0, 4'h0, E_SCH | E_OK | E_RH | E_PE);
    chk("R4 events ignored", {4'h0, status}, 8'h06);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_once_data();
    t_once_remote();
    t_rtr_answer();
    t_busy_write();
    t_preempt();
    t_priority();
    t_undef();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule